// File: doc/BRIEF.md
# Ten-to-one DDR lane serializer for a TMDS link

This block turns 10-bit encoded characters, one per pixel clock, into a serial stream at ten times the pixel rate. It does this without a 10x clock. A fast clock at five times the pixel rate drives it, and in every fast cycle it hands out two bits. The bit at index 0 of the pair belongs to the rising half of the fast cycle and the bit at index 1 to the falling half. A DDR output register outside the block turns each pair into line bits.

One top instance serves a whole link. It has a configurable number of data lanes, three by default, and one clock lane. The clock lane runs through the same lane logic, but its input is a constant pattern: five zeros sent first, then five ones. Its serial output therefore toggles once per pixel period.

Each lane keeps the incoming word in a holding register in the pixel domain. The fast domain copies that register into a shift register only at slot 0 of a five-slot cycle. The fast domain finds the pixel edge by watching a toggle flag that the pixel domain flips on every edge. Slot 0 is thereby tied to the pixel clock's rising edge.

Reset comes from an active-low asynchronous input. It takes effect at once in both domains and is released in each domain through its own two-flop synchronizer.

Top module: `tmds_lane_serializer`

## Requirements
- R1: While `rstN` is low, every bit of `dataPairs` and `clkPair` is 0, whatever `laneWords` holds.
- R2: A word is sent in five pairs in the order slot 0 to slot 4. Slot s carries word bit 2s at pair index 0 (sent first, rising half) and word bit 2s+1 at pair index 1. Bit 0 of the word therefore goes out first and bit 9 last.
- R3: A word present at pixel rising edge k appears during the five fast cycles that follow pixel rising edge k+1. Its slot 0 pair is registered on the fast edge that coincides with edge k+1.
- R4: A new word can be accepted on every pixel cycle. Consecutive words come out back to back, with no idle slot between them and no bits mixed from two words.
- R5: Data lane i takes its word from `laneWords[10*i+9:10*i]` and drives `dataPairs[2*i+1:2*i]`. Lanes do not affect one another.
- R6: The clock lane repeats the 10-bit pattern 1111100000 (bit 0 first), which gives the pairs 2'b00, 2'b00, 2'b10, 2'b11, 2'b11 in the same slots as the data lanes.
- R7: When `rstN` falls, the outputs become 0 at once, with no clock edge needed.
- R8: Changes on `laneWords` between two pixel rising edges have no effect. Only the value present at the rising edge is sent.
- R9: After reset is released, the outputs stay 0 until the fast domain has seen a pixel edge. From then on, slot 0 always falls on a pixel rising edge, so words come out whole and in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pixClk | input | 1 | Pixel clock, one word per rising edge |
| fastClk | input | 1 | Serial clock at five times the pixel rate, rising edges aligned with pixClk |
| rstN | input | 1 | Asynchronous active-low reset |
| laneWords | input | 10*DATA_LANES | Encoded characters, lane i in bits 10i+9..10i |
| dataPairs | output | 2*DATA_LANES | Bit pairs for the data lanes, lane i in bits 2i+1..2i, index 0 sent first |
| clkPair | output | 2 | Bit pair for the clock lane |

## Verification
The embedded properties assume three things about the inputs. The two clocks come from one source at an exact 1:5 ratio, with every pixel rising edge landing on a fast rising edge. The fast-domain reset is released no later than the first pixel toggle. `laneWords` settles well before each pixel edge. Under these conditions the fast domain can sample the pixel-domain toggle and holding register directly, and the alignment property holds. The stimulus generates both clocks from one timebase with the pixel edge at a fixed fast edge. It changes words only at the middle of a pixel period, and its glitch cases only right after an edge. It raises and drops reset between clock edges to reach the asynchronous paths.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // strobes from slot control to the lane datapaths (fast domain)
  typedef struct packed {
    logic load;  // copy holding register into shifter this edge
    logic run;   // slot phase is locked to the pixel clock
  } slotStrobe_t;
endpackage

// File: rtl/ser_reset_sync.sv
module ser_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  output logic rst
);
  logic [STAGES-1:0] syncQ;

  // asserts at once, releases after STAGES edges of clk
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[STAGES-2:0], 1'b0};
  end

  assign rst = syncQ[STAGES-1];
endmodule

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int SLOTS = 5
) (
  input  logic        pixClk,
  input  logic        pixRst,
  input  logic        fastClk,
  input  logic        fastRst,
  output slotStrobe_t strb
);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_ONE  = SLOT_W'(1);

  logic              pixToggle;
  logic              tglQ;
  logic              aligned;
  logic              edgeSeen;
  logic [SLOT_W-1:0] slotQ;

  // pixel domain: flips on every pixel rising edge
  always_ff @(posedge pixClk or posedge pixRst) begin
    if (pixRst) pixToggle <= 1'b0;
    else        pixToggle <= ~pixToggle;
  end

  // clocks are related: a single sample of the toggle is enough
  assign edgeSeen = pixToggle ^ tglQ;

  always_ff @(posedge fastClk or posedge fastRst) begin
    if (fastRst) begin
      tglQ    <= 1'b0;
      aligned <= 1'b0;
      slotQ   <= '0;
    end else begin
      tglQ <= pixToggle;
      if (edgeSeen) begin
        // previous fast edge was the pixel edge, i.e. slot 0
        aligned <= 1'b1;
        slotQ   <= SLOT_ONE;
      end else if (aligned) begin
        slotQ <= (slotQ == LAST_SLOT) ? '0 : slotQ + SLOT_ONE;
      end
    end
  end

  assign strb.run  = aligned;
  assign strb.load = aligned && (slotQ == LAST_SLOT);

  // R9: once locked, each observed pixel edge lands on slot 0
  align_chk: assert property (@(posedge fastClk) disable iff (fastRst)
    (aligned && edgeSeen) |-> (slotQ == '0));

  // R2
  slot_range_chk: assert property (@(posedge fastClk) disable iff (fastRst)
    slotQ <= LAST_SLOT);
endmodule

// File: rtl/ser_lane.sv
module ser_lane
  import ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              pixClk,
  input  logic              pixRst,
  input  logic              fastClk,
  input  logic              fastRst,
  input  logic [WORD_W-1:0] wordIn,
  input  slotStrobe_t       strb,
  output logic [1:0]        pairOut
);
  logic [WORD_W-1:0] holdQ;
  logic [WORD_W-1:0] shiftQ;
  logic [1:0]        pairQ;

  // pixel domain holding register
  always_ff @(posedge pixClk or posedge pixRst) begin
    if (pixRst) holdQ <= '0;
    else        holdQ <= wordIn;
  end

  // fast domain: whole word taken at slot 0, two bits leave per cycle
  always_ff @(posedge fastClk or posedge fastRst) begin
    if (fastRst) begin
      shiftQ <= '0;
      pairQ  <= 2'b00;
    end else if (!strb.run) begin
      shiftQ <= '0;
      pairQ  <= 2'b00;
    end else if (strb.load) begin
      pairQ  <= holdQ[1:0];
      shiftQ <= holdQ >> 2;
    end else begin
      pairQ  <= shiftQ[1:0];
      shiftQ <= shiftQ >> 2;
    end
  end

  assign pairOut = pairQ;

  // R1
  out_idle_chk: assert property (@(posedge fastClk) disable iff (fastRst)
    !strb.run |=> (pairQ == 2'b00));

  // R2
  load_pair_chk: assert property (@(posedge fastClk) disable iff (fastRst)
    strb.load |=> (pairQ == $past(holdQ[1:0])));
endmodule

// File: rtl/tmds_lane_serializer.sv
module tmds_lane_serializer
  import ser_pkg::*;
#(
  parameter int DATA_LANES = 3,
  parameter int WORD_W     = 10
) (
  input  logic                         pixClk,
  input  logic                         fastClk,
  input  logic                         rstN,
  input  logic [DATA_LANES*WORD_W-1:0] laneWords,
  output logic [DATA_LANES*2-1:0]      dataPairs,
  output logic [1:0]                   clkPair
);
  localparam int SLOTS = WORD_W / 2;
  localparam int HI_W  = WORD_W - WORD_W / 2;
  localparam logic [WORD_W-1:0] CLK_PATTERN = {{HI_W{1'b1}}, {(WORD_W/2){1'b0}}};

  logic        pixRst;
  logic        fastRst;
  slotStrobe_t strb;

  ser_reset_sync #(.STAGES(2)) u_pixRst (
    .clk(pixClk), .rstN(rstN), .rst(pixRst));

  ser_reset_sync #(.STAGES(2)) u_fastRst (
    .clk(fastClk), .rstN(rstN), .rst(fastRst));

  ser_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .pixClk(pixClk), .pixRst(pixRst),
    .fastClk(fastClk), .fastRst(fastRst),
    .strb(strb));

  for (genvar i = 0; i < DATA_LANES; i++) begin : g_data
    ser_lane #(.WORD_W(WORD_W)) u_lane (
      .pixClk(pixClk), .pixRst(pixRst),
      .fastClk(fastClk), .fastRst(fastRst),
      .wordIn(laneWords[i*WORD_W +: WORD_W]),
      .strb(strb),
      .pairOut(dataPairs[i*2 +: 2]));
  end

  ser_lane #(.WORD_W(WORD_W)) u_clkLane (
    .pixClk(pixClk), .pixRst(pixRst),
    .fastClk(fastClk), .fastRst(fastRst),
    .wordIn(CLK_PATTERN),
    .strb(strb),
    .pairOut(clkPair));
endmodule

// File: tb/test_tmds_lane_serializer.sv
module test_tmds_lane_serializer;
  logic        fastClk = 1'b0;
  logic        pixClk  = 1'b0;
  logic        rstN    = 1'b0;
  logic [29:0] laneWords = 30'h3FFFFFFF;
  logic [5:0]  dataPairs;
  logic [1:0]  clkPair;
  int total = 0;
  int bad   = 0;
  logic [29:0] seq [0:15];

  tmds_lane_serializer i_tmds_lane_serializer (
    .pixClk(pixClk), .fastClk(fastClk), .rstN(rstN),
    .laneWords(laneWords), .dataPairs(dataPairs), .clkPair(clkPair));

  // 100 MHz fast clock, pixel clock at one fifth, rising edges coincide
  initial forever #5 fastClk = ~fastClk;
  initial begin
    #25 pixClk = 1'b1;
    forever #25 pixClk = ~pixClk;
  end

  task automatic checkEq(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive seq[0..n-1] one per pixel cycle, compare rebuilt words two periods later
  task automatic runStream(int n, bit glitch, string req);
    logic [1:0] pr [4][5];
    logic [9:0] rebuilt;
    @(posedge pixClk);
    for (int p = 0; p < n + 2; p++) begin
      for (int s = 0; s < 5; s++) begin
        @(negedge fastClk);
        for (int l = 0; l < 3; l++) pr[l][s] = dataPairs[2*l +: 2];
        pr[3][s] = clkPair;
        if (s == 0 && glitch) laneWords = 30'h2AAAAAAA ^ 30'(p * 7919);
        if (s == 2) laneWords = (p < n) ? seq[p] : 30'h0;
      end
      if (p >= 2) begin
        for (int l = 0; l < 3; l++) begin
          rebuilt = {pr[l][4], pr[l][3], pr[l][2], pr[l][1], pr[l][0]};
          checkEq(req, $sformatf("lane%0d word%0d", l, p - 2), 32'(rebuilt),
                  32'(seq[p-2][10*l +: 10]));
        end
        // R6 clock lane pattern
        rebuilt = {pr[3][4], pr[3][3], pr[3][2], pr[3][1], pr[3][0]};
        checkEq("R6", "clock lane", 32'(rebuilt), 32'h3E0);
      end
    end
  endtask

  task automatic testResetState();
    // R1: outputs zero while reset held, inputs all ones
    for (int i = 0; i < 3; i++) begin
      repeat (3) @(negedge fastClk);
      checkEq("R1", "dataPairs in reset", 32'(dataPairs), 32'h0);
      checkEq("R1", "clkPair in reset", 32'(clkPair), 32'h0);
    end
    @(negedge pixClk);
    rstN = 1'b1;
    repeat (10) @(posedge pixClk);
  endtask

  task automatic testBitOrder();
    // R2: single-bit words expose the slot and pair positions
    seq[0] = {10'h020, 10'h200, 10'h001};
    seq[1] = {10'h002, 10'h100, 10'h010};
    runStream(2, 1'b0, "R2");
  endtask

  task automatic testLatencyStream();
    // R3 R4: back-to-back distinct words at the stated latency
    for (int i = 0; i < 8; i++)
      seq[i] = {10'(i * 37 + 5), 10'(10'h155 ^ i), 10'(1 << i)};
    runStream(8, 1'b0, "R3");
    seq[0] = {3{10'h155}}; seq[1] = {3{10'h2AA}};
    seq[2] = {3{10'h3FF}}; seq[3] = {3{10'h000}};
    seq[4] = {3{10'h2AA}}; seq[5] = {3{10'h155}};
    runStream(6, 1'b0, "R4");
  endtask

  task automatic testLaneIndependence();
    // R5: each lane carries its own word
    seq[0] = {10'h3FF, 10'h000, 10'h155};
    seq[1] = {10'h000, 10'h3FF, 10'h2AA};
    seq[2] = {10'h0F0, 10'h30F, 10'h0C3};
    runStream(3, 1'b0, "R5");
  endtask

  task automatic testGlitch();
    // R8: mid-period changes right after an edge are not sent
    seq[0] = {10'h111, 10'h222, 10'h333};
    seq[1] = {10'h044, 10'h055, 10'h066};
    seq[2] = {10'h377, 10'h188, 10'h099};
    runStream(3, 1'b1, "R8");
  endtask

  task automatic testAsyncReset();
    laneWords = 30'h3FFFFFFF;
    repeat (3) @(posedge pixClk);
    @(negedge fastClk);
    checkEq("R7", "ones before reset", 32'(dataPairs), 32'h3F);
    #2 rstN = 1'b0;
    #1;
    // R7: no clock edge between reset assertion and this sample
    checkEq("R7", "dataPairs after async reset", 32'(dataPairs), 32'h0);
    checkEq("R7", "clkPair after async reset", 32'(clkPair), 32'h0);
    repeat (4) @(negedge fastClk);
    checkEq("R1", "dataPairs held in reset", 32'(dataPairs), 32'h0);
    @(negedge pixClk);
    rstN = 1'b1;
    repeat (10) @(posedge pixClk);
    // R9: re-locks and delivers whole words after release
    seq[0] = {10'h2C5, 10'h13A, 10'h0FF};
    seq[1] = {10'h001, 10'h3FE, 10'h200};
    seq[2] = {10'h1E1, 10'h21E, 10'h333};
    runStream(3, 1'b0, "R9");
  endtask

  initial begin
    #(10 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testResetState();
    testBitOrder();
    testLatencyStream();
    testLaneIndependence();
    testGlitch();
    testAsyncReset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule